// File: doc/BRIEF.md
# Round-Robin Set Tag Store

This block holds the tags of one cache set and chooses which way to overwrite next with a rotating pointer. The number of active ways can be changed at run time, from one up to a compile-time maximum. A lookup compares a tag against every active way in the same cycle and reports a hit. A fill writes a new tag into the way the pointer names, and the pointer then steps down by one.

No way carries a valid or dirty bit. Tags cleared to zero by reset therefore count as real entries, and a lookup of tag zero hits until each active way has been overwritten. Ways above the active count keep their contents but are never compared and never chosen. A configure request always reloads the pointer with the highest active index. A request outside the legal range is rejected, and the block reports that for one cycle.

Top module: `rr_tag_set`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) clears every tag to zero, makes all MAX_WAYS ways active, sets victim_idx to MAX_WAYS-1 and drives cfg_err low.
- R2: hit is combinational. It is 1 in the same cycle when lookup_en is 1 and some active way holds a tag equal to lookup_tag. Tag zero left by reset matches like any other value.
- R3: A fill (fill_en high and cfg_en low at a rising edge) writes fill_tag into the way victim_idx names. A lookup sees the new tag from the next cycle on.
- R4: After each fill, victim_idx decreases by one. From 0 it wraps to the highest active index (active ways minus one).
- R5: A configure with cfg_ways in 1..MAX_WAYS sets the active count to cfg_ways. From the next cycle victim_idx equals cfg_ways-1. Stored tags are not changed.
- R6: A configure with cfg_ways equal to 0 or greater than MAX_WAYS changes neither the active count nor victim_idx. It raises cfg_err for exactly the next cycle.
- R7: Ways with index above the highest active index never produce a hit and are never written. Their tags hit again once the count is raised to cover them.
- R8: When cfg_en and fill_en are both high at the same edge, the configure acts and the fill is dropped: no tag is written and the pointer follows the configure rule.
- R9: hit is 0 whenever lookup_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lookup_en | input | 1 | Lookup strobe |
| lookup_tag | input | TAG_W | Tag to compare against the active ways |
| hit | output | 1 | Lookup matched an active way |
| fill_en | input | 1 | Replace strobe |
| fill_tag | input | TAG_W | Tag written into the victim way |
| cfg_en | input | 1 | Configure strobe |
| cfg_ways | input | $clog2(MAX_WAYS+1) | Requested number of active ways |
| cfg_err | output | 1 | One-cycle flag for a rejected configure |
| victim_idx | output | $clog2(MAX_WAYS) | Way the next fill will overwrite |

## Verification
The assertions assume that rst is high at the first clock edge and that the strobes and cfg_ways carry known values at every edge after that. They make no assumption about how often the strobes occur, because a lookup, a fill and a configure can all come in one cycle. The bench drives every input on falling edges and holds it through the following rising edge, and it starts with reset asserted. It also deliberately puts a fill and a configure in the same cycle, and sends a count of zero and a count above the maximum.

// File: rtl/rr_tag_pkg.sv
package rr_tag_pkg;

    // Action taken by the set at a clock edge
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_FILL    = 2'd1,
        OP_CFG     = 2'd2,
        OP_CFG_BAD = 2'd3
    } set_op_e;

    // A way count is legal when it is 1..max
    function automatic logic ways_ok(input int unsigned n, input int unsigned max_n);
        return (n != 0) && (n <= max_n);
    endfunction

    // Downward rotation with wrap to the last active way
    function automatic int unsigned step_down(input int unsigned cur, input int unsigned last);
        return (cur == 0) ? last : cur - 1;
    endfunction

    // Configure outranks fill
    function automatic set_op_e decode_op(input logic fill, input logic cfg, input logic ok);
        if (cfg)       return ok ? OP_CFG : OP_CFG_BAD;
        else if (fill) return OP_FILL;
        else           return OP_IDLE;
    endfunction

endpackage

// File: rtl/rr_way_ctrl.sv
module rr_way_ctrl
    import rr_tag_pkg::*;
#(
    parameter int unsigned MAX_WAYS = 4,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic             cfg_en,
    input  logic [CNT_W-1:0] cfg_ways,
    output logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] victim_idx,
    output logic             wr_en,
    output logic             cfg_err
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAX_WAYS - 1);

    logic    cfg_ok;
    set_op_e op;

    always_comb begin
        cfg_ok = ways_ok(32'(cfg_ways), MAX_WAYS);
        op     = decode_op(fill_en, cfg_en, cfg_ok);
        wr_en  = (op == OP_FILL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_idx   <= TOP_IDX;
            victim_idx <= TOP_IDX;
            cfg_err    <= 1'b0;
        end else begin
            cfg_err <= (op == OP_CFG_BAD);
            case (op)
                OP_FILL: victim_idx <= IDX_W'(step_down(32'(victim_idx), 32'(last_idx)));
                OP_CFG: begin
                    last_idx   <= IDX_W'(cfg_ways - 1'b1);
                    victim_idx <= IDX_W'(cfg_ways - 1'b1);
                end
                default: ;
            endcase
        end
    end

    // R7: the pointer never leaves the active range
    a_r7_victim_in_range: assert property (@(posedge clk) disable iff (rst)
        victim_idx <= last_idx);

    // R4: a fill rotates the pointer downward with wrap
    a_r4_fill_rotates: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !cfg_en) |=> (($past(victim_idx) == '0) ? (victim_idx == $past(last_idx))
                                                           : (victim_idx == $past(victim_idx) - 1'b1)));

    // R5, R8: a legal configure reloads the pointer, even alongside a fill
    a_r5_cfg_reload: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_ok) |=> ((last_idx == IDX_W'($past(cfg_ways) - 1'b1)) && (victim_idx == last_idx)));

    // R6: a rejected configure keeps state and flags one cycle
    a_r6_bad_cfg_kept: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !cfg_ok) |=> (cfg_err && $stable(last_idx) && $stable(victim_idx)));

    a_r6_err_has_cause: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $past(cfg_en));

endmodule

// File: rtl/rr_tag_array.sv
module rr_tag_array #(
    parameter int unsigned MAX_WAYS = 4,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned TAG_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             lookup_en,
    input  logic [TAG_W-1:0] lookup_tag,
    output logic             hit
);

    logic [TAG_W-1:0]    tags [MAX_WAYS];
    logic [MAX_WAYS-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < int'(MAX_WAYS); w++) tags[w] <= '0;
        end else if (wr_en) begin
            tags[wr_idx] <= wr_tag;
        end
    end

    for (genvar w = 0; w < int'(MAX_WAYS); w++) begin : g_way
        assign match[w] = (IDX_W'(w) <= last_idx) && (tags[w] == lookup_tag);
    end

    assign hit = lookup_en && (|match);

    // R3: an accepted fill lands in the addressed way
    a_r3_fill_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tags[$past(wr_idx)] == $past(wr_tag)));

    // R7: writes stay inside the active range
    a_r7_write_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx <= last_idx));

    // R9: no hit without a lookup strobe
    a_r9_hit_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        hit |-> lookup_en);

endmodule

// File: rtl/rr_tag_set.sv
module rr_tag_set #(
    parameter int unsigned TAG_W    = 16,
    parameter int unsigned MAX_WAYS = 4,
    localparam int unsigned IDX_W   = (MAX_WAYS > 1) ? $clog2(MAX_WAYS) : 1,
    localparam int unsigned CNT_W   = $clog2(MAX_WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lookup_en,
    input  logic [TAG_W-1:0] lookup_tag,
    output logic             hit,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             cfg_en,
    input  logic [CNT_W-1:0] cfg_ways,
    output logic             cfg_err,
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] last_idx;
    logic             wr_en;

    rr_way_ctrl #(
        .MAX_WAYS (MAX_WAYS),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .fill_en    (fill_en),
        .cfg_en     (cfg_en),
        .cfg_ways   (cfg_ways),
        .last_idx   (last_idx),
        .victim_idx (victim_idx),
        .wr_en      (wr_en),
        .cfg_err    (cfg_err)
    );

    rr_tag_array #(
        .MAX_WAYS (MAX_WAYS),
        .IDX_W    (IDX_W),
        .TAG_W    (TAG_W)
    ) tags_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_idx     (victim_idx),
        .wr_tag     (fill_tag),
        .last_idx   (last_idx),
        .lookup_en  (lookup_en),
        .lookup_tag (lookup_tag),
        .hit        (hit)
    );

    // R8: a configure and a fill together never write a tag
    a_r8_cfg_blocks_fill: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> !wr_en);

endmodule

// File: tb/rr_tag_set_tb_top.sv
`timescale 1ns/100ps
module rr_tag_set_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lookup_en = 1'b0;
    logic [15:0] lookup_tag = '0;
    logic        hit;
    logic        fill_en = 1'b0;
    logic [15:0] fill_tag = '0;
    logic        cfg_en = 1'b0;
    logic [2:0]  cfg_ways = '0;
    logic        cfg_err;
    logic [1:0]  victim_idx;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rr_tag_set #(.TAG_W(16), .MAX_WAYS(4)) dut_i (
        .clk(clk), .rst(rst), .lookup_en(lookup_en), .lookup_tag(lookup_tag), .hit(hit),
        .fill_en(fill_en), .fill_tag(fill_tag), .cfg_en(cfg_en), .cfg_ways(cfg_ways),
        .cfg_err(cfg_err), .victim_idx(victim_idx)
    );

    typedef struct packed {
        logic        c_en;
        logic [2:0]  c_ways;
        logic        f_en;
        logic [15:0] f_tag;
        logic [15:0] l_tag;
        logic        e_hit;
        logic [1:0]  e_vic;
        logic        e_err;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 2'd3, 1'b0},
        '{1'b0, 3'd0, 1'b1, 16'hAAAA, 16'hAAAA, 1'b1, 2'd2, 1'b0},
        '{1'b0, 3'd0, 1'b1, 16'hBBBB, 16'h1234, 1'b0, 2'd1, 1'b0},
        '{1'b0, 3'd0, 1'b1, 16'hCCCC, 16'hCCCC, 1'b1, 2'd0, 1'b0},
        '{1'b0, 3'd0, 1'b1, 16'hDDDD, 16'h0000, 1'b0, 2'd3, 1'b0},
        '{1'b0, 3'd0, 1'b1, 16'hEEEE, 16'hAAAA, 1'b0, 2'd2, 1'b0},
        '{1'b1, 3'd2, 1'b0, 16'h0000, 16'hBBBB, 1'b0, 2'd1, 1'b0},
        '{1'b0, 3'd0, 1'b0, 16'h0000, 16'hCCCC, 1'b1, 2'd1, 1'b0},
        '{1'b0, 3'd0, 1'b1, 16'h1111, 16'hCCCC, 1'b0, 2'd0, 1'b0},
        '{1'b0, 3'd0, 1'b1, 16'h2222, 16'h2222, 1'b1, 2'd1, 1'b0},
        '{1'b1, 3'd5, 1'b0, 16'h0000, 16'hEEEE, 1'b0, 2'd1, 1'b1},
        '{1'b1, 3'd0, 1'b0, 16'h0000, 16'h1111, 1'b1, 2'd1, 1'b1},
        '{1'b1, 3'd4, 1'b1, 16'h9999, 16'h9999, 1'b0, 2'd3, 1'b0},
        '{1'b0, 3'd0, 1'b0, 16'h0000, 16'hBBBB, 1'b1, 2'd3, 1'b0},
        '{1'b1, 3'd1, 1'b0, 16'h0000, 16'h1111, 1'b0, 2'd0, 1'b0},
        '{1'b0, 3'd0, 1'b1, 16'h3333, 16'h3333, 1'b1, 2'd0, 1'b0},
        '{1'b0, 3'd0, 1'b1, 16'h4444, 16'h3333, 1'b0, 2'd0, 1'b0},
        '{1'b1, 3'd4, 1'b0, 16'h0000, 16'hEEEE, 1'b1, 2'd3, 1'b0}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_en = 1'b0; fill_en = 1'b0; lookup_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // Reset state and strobe gating
        lookup_tag = 16'h0000; lookup_en = 1'b0;
        #0.5;
        chk("R9 hit without lookup_en", 32'(hit), 32'd0);
        chk("R1 victim after reset", 32'(victim_idx), 32'd3);
        chk("R1 cfg_err after reset", 32'(cfg_err), 32'd0);
        lookup_en = 1'b1;
        #0.5;
        chk("R1 R2 zero tag hits after reset", 32'(hit), 32'd1);

        // Table walk: one operation per row, then lookup and state check
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            lookup_en = 1'b0;
            cfg_en = TBL[i].c_en; cfg_ways = TBL[i].c_ways;
            fill_en = TBL[i].f_en; fill_tag = TBL[i].f_tag;
            @(posedge clk);
            #0.5;
            cfg_en = 1'b0; fill_en = 1'b0;
            lookup_en = 1'b1; lookup_tag = TBL[i].l_tag;
            #0.5;
            chk($sformatf("row %0d R2 R3 R7 R8 hit", i), 32'(hit), 32'(TBL[i].e_hit));
            chk($sformatf("row %0d R4 R5 R6 victim", i), 32'(victim_idx), 32'(TBL[i].e_vic));
            chk($sformatf("row %0d R6 cfg_err", i), 32'(cfg_err), 32'(TBL[i].e_err));
        end

        // Directed: lookup_en low while a matching tag is present
        @(negedge clk);
        lookup_en = 1'b0; lookup_tag = 16'hEEEE;
        #0.5;
        chk("R9 stored tag without strobe", 32'(hit), 32'd0);

        // Directed: reset in mid-run clears tags and count
        do_reset();
        lookup_en = 1'b1; lookup_tag = 16'hEEEE;
        #0.5;
        chk("R1 old tag gone after reset", 32'(hit), 32'd0);
        chk("R1 victim back to top", 32'(victim_idx), 32'd3);
        lookup_tag = 16'h0000;
        #0.5;
        chk("R1 zero tag hits again", 32'(hit), 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule